// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block collects eight interrupt request lines, numbered 0 to 7, and drives a single interrupt line to a host processor. It keeps three 8-bit registers. The pending register records requests. The in-service register marks levels that have been acknowledged and are still being handled. The mask register disables levels chosen by software.

A priority resolver chooses the best unmasked pending level. It raises the interrupt line only when that level outranks every level currently in service. The host acknowledges with two pulses on `ack`. One cycle after the second pulse, the block presents an 8-bit vector: a programmable 5-bit base in the upper bits and the level number in the lower three.

Priority is fixed (0 highest) or rotating. Each line is edge- or level-detected. End-of-interrupt is specific, non-specific or automatic. A polled mode lets the host read the best level through the data port instead of taking a vectored interrupt. All configuration goes through a synchronous command port: `cmd_addr` 0 = mask, 1 = mode (bit0 rotate, bit1 auto-EOI, bit2 poll), 2 = trigger select (bit i = 1 makes line i level-sensitive), 3 = vector base (`cmd_data[7:3]`), 4 = end-of-interrupt (bit3 = specific, bits 2:0 = level).

Top module: `irq_vec_ctrl`

## Requirements
- R1: `int_out` is high exactly when an unmasked pending level exists whose priority is above every in-service level, and polled mode is off; a masked level never raises it.
- R2: On the first `ack` pulse, the winning level's in-service bit is set. One cycle after the second `ack` pulse, `vec_vld` is high for one cycle with `vec_out = {base, level}`.
- R3: If no level qualifies at the first `ack` pulse, the in-service register is left unchanged and the vector carries level 7.
- R4: With fixed priority, level 0 ranks highest and level 7 lowest. A pending level ranked below an in-service level is held off, and a level ranked above it nests.
- R5: In rotating mode, the level named by an end-of-interrupt, or the level finished by automatic end-of-interrupt, becomes the lowest priority. Any write to the mode register restores the order 0..7.
- R6: An edge-sensitive line is captured on a low-to-high change and stays pending until granted. A level-sensitive line's pending bit follows the line one cycle later and is not cleared by a grant.
- R7: A non-specific end-of-interrupt (`cmd_data[3]=0`) clears the highest-ranked in-service bit. A specific one (`cmd_data[3]=1`) clears bit `cmd_data[2:0]`.
- R8: In auto-EOI mode, the granted in-service bit is cleared at the second `ack` pulse.
- R9: In polled mode, `int_out` stays low. A read at `rd_addr` 3 returns `{valid, 4'b0, level}` (level 0 when not valid) and acts as the acknowledge: it sets the in-service bit and clears an edge pending bit.
- R10: Reads at `rd_addr` 0, 1 and 2 return the mask, pending and in-service registers. After reset all three are zero and priority is fixed.
- R11: When a grant and an end-of-interrupt touch the same cycle, the grant's set wins over the clear. Rotation caused by an acknowledge wins over rotation caused by the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines |
| int_out | output | 1 | Interrupt to host |
| ack | input | 1 | Acknowledge pulse, two per sequence |
| vec_vld | output | 1 | Vector valid strobe |
| vec_out | output | 8 | Interrupt vector |
| cmd_we | input | 1 | Command write strobe |
| cmd_addr | input | 3 | Command register select |
| cmd_data | input | 8 | Command write data |
| rd_en | input | 1 | Read strobe (side effect only at address 3) |
| rd_addr | input | 2 | Read select |
| rd_data | output | 8 | Read data, combinational |

## Verification
The collision that matters is a first `ack` pulse landing in the same cycle as an end-of-interrupt write. Both change the in-service register, and in rotating mode both can move the lowest-priority pointer. The bench provokes this by holding `ack` high while issuing a non-specific end-of-interrupt, and then a specific one naming the level being granted. A behavioural reference model advances every clock, and the bench judges the result from the in-service readback, the vector level and `int_out` on the following cycles.

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       ack,
  output logic       vec_vld,
  output logic [7:0] vec_out,
  input  logic       cmd_we,
  input  logic [2:0] cmd_addr,
  input  logic [7:0] cmd_data,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data
);
  logic [7:0] irq_q, pend, isr, mask, lvl_mode;
  logic [4:0] base;
  logic       rot, aeoi, poll, phase, spur;
  logic [2:0] lowp, sel;

  function automatic logic [2:0] rnk(input logic [2:0] l, input logic [2:0] lo);
    rnk = l - lo - 3'd1;
  endfunction

  function automatic logic [3:0] top(input logic [7:0] v, input logic [2:0] lo);
    logic [2:0] l;
    top = 4'd0;
    for (int k = 7; k >= 0; k--) begin
      l = lo + 3'(k + 1);
      if (v[l]) top = {1'b1, l};
    end
  endfunction

  wire [2:0] low    = rot ? lowp : 3'd7;
  wire [3:0] rq     = top(pend & ~mask, low);
  wire [3:0] sv     = top(isr, low);
  wire       win_ok = rq[3] && (!sv[3] || rnk(rq[2:0], low) < rnk(sv[2:0], low));

  assign int_out = win_ok && !poll;

  wire       poll_rd  = rd_en && rd_addr == 2'd3;
  wire       take1    = ack && !phase;
  wire       take2    = ack && phase;
  wire       grant    = (take1 || poll_rd) && win_ok;
  wire       cmd_eoi  = cmd_we && cmd_addr == 3'd4;
  wire [2:0] eoi_lvl  = cmd_data[3] ? cmd_data[2:0] : sv[2:0];
  wire       eoi_hit  = cmd_eoi && (cmd_data[3] || sv[3]);
  wire       ae_done  = take2 && aeoi && !spur;
  wire [7:0] g_bit    = grant   ? 8'd1 << rq[2:0] : 8'd0;
  wire [7:0] e_bit    = eoi_hit ? 8'd1 << eoi_lvl : 8'd0;
  wire [7:0] a_bit    = ae_done ? 8'd1 << sel     : 8'd0;
  wire [7:0] rise     = irq_in & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0; pend <= '0; isr <= '0; mask <= '0; lvl_mode <= '0;
      base <= '0; rot <= 1'b0; aeoi <= 1'b0; poll <= 1'b0;
      lowp <= 3'd7; phase <= 1'b0; spur <= 1'b0; sel <= '0;
      vec_vld <= 1'b0; vec_out <= '0;
    end else begin
      irq_q <= irq_in;
      pend  <= (lvl_mode & irq_in) | (~lvl_mode & ((pend & ~g_bit) | rise));
      isr   <= (isr & ~e_bit & ~a_bit) | g_bit;
      if (ack) phase <= !phase;
      if (take1) begin
        sel  <= win_ok ? rq[2:0] : 3'd7;
        spur <= !win_ok;
      end
      vec_vld <= take2;
      if (take2) vec_out <= {base, sel};
      if (cmd_we && cmd_addr == 3'd1) lowp <= 3'd7;
      else if (ae_done && rot)        lowp <= sel;
      else if (eoi_hit && rot)        lowp <= eoi_lvl;
      if (cmd_we) begin
        case (cmd_addr)
          3'd0: mask <= cmd_data;
          3'd1: {poll, aeoi, rot} <= cmd_data[2:0];
          3'd2: lvl_mode <= cmd_data;
          3'd3: base <= cmd_data[7:3];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0: rd_data = mask;
      2'd1: rd_data = pend;
      2'd2: rd_data = isr;
      default: rd_data = {win_ok, 4'b0, win_ok ? rq[2:0] : 3'd0};
    endcase
  end

  a_r2_vec_after_second: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> $past(ack && phase));
  a_r3_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !phase && !win_ok && !cmd_we) |=> isr == $past(isr));
  a_r4_grant_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !phase && int_out && !cmd_eoi) |=> $countones(isr) == $countones($past(isr)) + 1);
  a_r7_specific_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eoi && cmd_data[3] && !ack && !poll_rd) |=> !isr[$past(cmd_data[2:0])]);
  a_r10_mask_written: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_addr == 3'd0) |=> mask == $past(cmd_data));
endmodule

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] irq = 0, cmd_data = 0;
  logic ack = 0, cmd_we = 0, rd_en = 0;
  logic [2:0] cmd_addr = 0;
  logic [1:0] rd_addr = 0;
  wire int_out, vec_vld;
  wire [7:0] vec_out, rd_data;
  int checks = 0, fails = 0;
  string cur = "R10";

  always #2 clk = ~clk;

  irq_vec_ctrl dut (.clk(clk), .rst_n(rst_n), .irq_in(irq), .int_out(int_out), .ack(ack),
    .vec_vld(vec_vld), .vec_out(vec_out), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  // reference model
  bit [7:0] mp, mi, mm, mlev, mq, evec;
  bit [4:0] mbase;
  bit mrot, maeoi, mpoll, mph, mspur, evld;
  int mlow = 7, msel = 0;

  function automatic int rk(int l, int lo); return (l - lo + 7) % 8; endfunction
  function automatic int best(bit [7:0] v, int lo);
    int b = -1;
    for (int i = 0; i < 8; i++) if (v[i] && (b < 0 || rk(i, lo) < rk(b, lo))) b = i;
    return b;
  endfunction
  function automatic bit m_ok();
    int lo = mrot ? mlow : 7;
    int r = best(mp & ~mm, lo), s = best(mi, lo);
    return r >= 0 && (s < 0 || rk(r, lo) < rk(s, lo));
  endfunction

  always @(posedge clk) begin : mdl
    int lo, r, s, el;
    bit ok, pr, gr, eh, ae;
    bit [7:0] ni, np;
    if (!rst_n) begin
      mp = 0; mi = 0; mm = 0; mlev = 0; mq = 0; mbase = 0; mrot = 0; maeoi = 0;
      mpoll = 0; mph = 0; mspur = 0; mlow = 7; msel = 0; evld = 0; evec = 0;
    end else begin
      lo = mrot ? mlow : 7;
      r = best(mp & ~mm, lo); s = best(mi, lo); ok = m_ok();
      pr = rd_en && rd_addr == 3;
      gr = ((ack && !mph) || pr) && ok;
      eh = 0; el = 0;
      ni = mi;
      if (cmd_we && cmd_addr == 4) begin
        el = cmd_data[3] ? int'(cmd_data[2:0]) : s;
        if (cmd_data[3] || s >= 0) begin eh = 1; ni[el] = 0; end
      end
      ae = ack && mph && maeoi && !mspur;
      if (ae) ni[msel] = 0;
      if (gr) ni[r] = 1;
      for (int i = 0; i < 8; i++)
        np[i] = mlev[i] ? irq[i] : ((mp[i] && !(gr && r == i)) || (irq[i] && !mq[i]));
      evld = ack && mph;
      if (ack && mph) evec = {mbase, 3'(msel)};
      if (cmd_we && cmd_addr == 1) mlow = 7;
      else if (ae && mrot) mlow = msel;
      else if (eh && mrot) mlow = el;
      if (ack && !mph) begin msel = ok ? r : 7; mspur = !ok; end
      if (ack) mph = !mph;
      if (cmd_we) case (cmd_addr)
        0: mm = cmd_data;
        1: begin mrot = cmd_data[0]; maeoi = cmd_data[1]; mpoll = cmd_data[2]; end
        2: mlev = cmd_data;
        3: mbase = cmd_data[7:3];
        default: ;
      endcase
      mi = ni; mp = np; mq = irq;
    end
  end

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", cur, what, got, exp);
    end
  endtask

  task automatic check_all();
    int lo = mrot ? mlow : 7;
    int r = best(mp & ~mm, lo);
    bit ok = m_ok();
    bit [7:0] er;
    chk("int_out", int_out, ok && !mpoll);
    chk("vec_vld", vec_vld, evld);
    if (evld) chk("vec_out", vec_out, evec);
    case (rd_addr)
      0: er = mm;
      1: er = mp;
      2: er = mi;
      default: er = {ok, 4'b0, ok ? 3'(r) : 3'd0};
    endcase
    chk("rd_data", rd_data, er);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    if (rst_n) check_all();
  endtask
  task automatic wr(int a, int d);
    cmd_we = 1; cmd_addr = 3'(a); cmd_data = 8'(d); tick(); cmd_we = 0;
  endtask
  task automatic rd(int a);
    rd_addr = 2'(a);
    if (a == 3) rd_en = 1;
    tick(); rd_en = 0;
  endtask
  task automatic ack_seq();
    ack = 1; tick(); tick(); ack = 0; tick();
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur = "R10"; rd(0); rd(1); rd(2);
    chk("reset mask", rd_data, 0);
    wr(0, 8'h20); rd(0);
    cur = "R1"; irq[5] = 1; tick(); tick(); chk("masked int", int_out, 0);
    irq[3] = 1; tick(); tick(); chk("int raised", int_out, 1);
    cur = "R2"; wr(3, 8'hA8); ack_seq(); rd(2);
    cur = "R4"; irq[6] = 1; tick(); tick(); chk("held off", int_out, 0);
    irq[1] = 1; tick(); tick(); ack_seq(); rd(2);
    cur = "R7"; wr(4, 0); rd(2); wr(4, 8'h0B); rd(2); ack_seq(); wr(4, 0); rd(2);
    cur = "R6"; irq = 0; tick(); wr(0, 0); tick(); ack_seq(); wr(4, 0);
    wr(2, 8'h04); irq[2] = 1; tick(); rd(1); tick(); rd(1);
    cur = "R3"; irq[2] = 0; tick(); ack_seq(); rd(2);
    cur = "R5"; wr(1, 1); irq = 0; tick(); irq[0] = 1; irq[4] = 1; tick(); tick();
    ack_seq(); wr(4, 0); ack_seq(); wr(4, 0);
    irq = 0; tick(); irq[0] = 1; irq[5] = 1; tick(); tick(); ack_seq(); wr(4, 0); rd(2);
    ack_seq(); wr(4, 0);
    cur = "R8"; wr(1, 3); irq = 0; tick(); irq = 8'h81; tick(); tick();
    ack_seq(); rd(2); ack_seq(); rd(2);
    cur = "R11"; wr(1, 0); irq = 0; tick(); irq[6] = 1; tick(); tick(); ack_seq();
    irq[2] = 1; tick(); tick();
    ack = 1; cmd_we = 1; cmd_addr = 4; cmd_data = 0; tick(); cmd_we = 0; tick(); ack = 0; tick();
    rd(2);
    wr(4, 8'h0A); irq[2] = 1; tick();
    ack = 1; cmd_we = 1; cmd_addr = 4; cmd_data = 8'h0A; tick(); cmd_we = 0; tick(); ack = 0; tick();
    rd(2); wr(4, 0);
    cur = "R9"; wr(1, 4); irq = 0; tick(); irq[3] = 1; tick(); tick();
    chk("poll int low", int_out, 0);
    rd(3); rd(3); rd(2); rd(1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule